// File: doc/BRIEF.md
# Serial Receive Path with Per-Character Error Tags

This block turns an asynchronous serial input into characters and queues them for a host. A baud enable pulses sixteen times per bit period. The block looks for a falling edge on the line and confirms a start bit at the centre of that bit. It then samples each data bit, the optional parity bit and one or two stop bits at their centres.

Each finished character goes into a 16-entry first-in first-out queue with three tags: parity error, framing error and break. Reading the queue shows the oldest character combinationally on `rd_data_o`, and a one-cycle `rd_i` pulse removes it. A separate status-read strobe clears the sticky line indicators.

The block drives these outputs for the surrounding interrupt logic:
- data-ready
- overrun
- parity, framing and break indicators, which follow the character at the head of the queue
- a flag that says some queued character is tagged
- a trigger flag, raised when the fill level reaches a chosen threshold

Register decoding and the baud generator sit outside this block.

Top module: `serial_rx_core`

## Requirements
- R1: A low line seen at a tick after a high one starts a candidate start bit. If the line is high again at the eighth tick after that edge, the candidate is dropped and nothing is stored.
- R2: Data bits are taken least significant first, one every 16 ticks. The number of bits is set by `word_len_i`: 0=5, 1=6, 2=7, 3=8. Unused upper bits of `rd_data_o` read as zero.
- R3: When `parity_en_i` is 1, one parity bit follows the data bits. `parity_even_i`=1 selects even parity and 0 selects odd parity. A mismatch sets the character's parity tag.
- R4: A low first stop bit, or a low second stop bit when `two_stop_i`=1, sets the character's framing tag. The receiver then waits for the next falling edge, and the next character is received correctly.
- R5: A character whose data bits, parity bit and first stop bit are all low is a break. It is stored once as 0x00 with only the break tag. Nothing more is received until the line is high at a tick; after that, reception resumes.
- R6: The queue holds 16 characters. `rd_data_o` shows the oldest one, `count_o` gives the fill level, and `rd_i` removes one entry. An `rd_i` on an empty queue has no effect.
- R7: A character that completes while the queue is full, with no removal in that cycle, is discarded. The queue contents are kept and `overrun_o` is set.
- R8: `parity_err_o`, `framing_err_o` and `break_o` are set when a character carrying that tag becomes the head of the queue. These three and `overrun_o` stay set until a one-cycle `status_rd_i` pulse clears them; a new set in the same cycle wins over the clear.
- R9: `data_ready_o` is 1 exactly when `count_o` is nonzero.
- R10: `fifo_err_o` is 1 while at least one queued character carries any tag.
- R11: `trig_o` is 1 when `count_o` is at least the level chosen by `trig_sel_i`: 0=1, 1=4, 2=8, 3=14.
- R12: A `fifo_clr_i` pulse empties the queue, so `count_o`, `data_ready_o` and `fifo_err_o` read 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Enable pulsed 16 times per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| word_len_i | input | 2 | Data bits per character minus five |
| parity_en_i | input | 1 | A parity bit follows the data bits |
| parity_even_i | input | 1 | 1 even parity, 0 odd parity |
| two_stop_i | input | 1 | Two stop bits expected |
| trig_sel_i | input | 2 | Threshold code for `trig_o` |
| rd_i | input | 1 | Remove the head character |
| fifo_clr_i | input | 1 | Empty the queue |
| status_rd_i | input | 1 | Clear the sticky indicators |
| rd_data_o | output | 8 | Head character |
| count_o | output | 5 | Number of queued characters |
| data_ready_o | output | 1 | Queue is not empty |
| overrun_o | output | 1 | Sticky overrun indicator |
| parity_err_o | output | 1 | Sticky parity indicator from the head |
| framing_err_o | output | 1 | Sticky framing indicator from the head |
| break_o | output | 1 | Sticky break indicator from the head |
| fifo_err_o | output | 1 | Some queued character is tagged |
| trig_o | output | 1 | Fill level at or above the threshold |

## Verification
The properties assume the following about the inputs:
- `tick16_i` is a single-cycle enable.
- The framing settings stay constant while a character is on the line.
- `rd_i`, `status_rd_i` and `fifo_clr_i` are short strobes.

The stimulus changes the word length, parity and stop settings only while the line idles high between characters. It holds every bit for exactly sixteen ticks and pulses each strobe for one clock. Between characters it waits long enough for a stored character to reach the sticky indicators.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16_i,
  input  logic                       rxd_i,
  input  logic [1:0]                 word_len_i,
  input  logic                       parity_en_i,
  input  logic                       parity_even_i,
  input  logic                       two_stop_i,
  input  logic [1:0]                 trig_sel_i,
  input  logic                       rd_i,
  input  logic                       fifo_clr_i,
  input  logic                       status_rd_i,
  output logic [7:0]                 rd_data_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       data_ready_o,
  output logic                       overrun_o,
  output logic                       parity_err_o,
  output logic                       framing_err_o,
  output logic                       break_o,
  output logic                       fifo_err_o,
  output logic                       trig_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP, HOLD} st_t;

  logic [1:0]    sync_q;
  logic          rx;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          par_q, stop2, prev_q;
  logic          done_q;
  logic [7:0]    done_data;
  logic [2:0]    done_tag;

  logic          samp, par_bad, zero_w;
  logic [7:0]    char_w;

  assign rx      = sync_q[1];
  assign samp    = tick16_i && (cnt == CW'(OSR-1));
  assign char_w  = shreg >> (2'd3 - word_len_i);
  assign par_bad = (^{char_w, par_q}) ^ ~parity_even_i;
  assign zero_w  = (char_w == 8'd0) && !par_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      par_q     <= 1'b0;
      stop2     <= 1'b0;
      prev_q    <= 1'b1;
      done_q    <= 1'b0;
      done_data <= '0;
      done_tag  <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick16_i) prev_q <= rx;
      case (st)
        IDLE:
          if (tick16_i && prev_q && !rx) begin
            st  <= START;
            cnt <= '0;
          end
        START:
          if (tick16_i) begin
            if (cnt == CW'(OSR/2-1)) begin
              cnt   <= '0;
              bitn  <= '0;
              par_q <= 1'b0;
              stop2 <= 1'b0;
              st    <= rx ? IDLE : DATA;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        DATA:
          if (tick16_i) begin
            cnt <= cnt + CW'(1);
            if (samp) begin
              shreg <= {rx, shreg[7:1]};
              bitn  <= bitn + 3'd1;
              if (bitn == ({1'b0, word_len_i} + 3'd4))
                st <= parity_en_i ? PAR : STOP;
            end
          end
        PAR:
          if (tick16_i) begin
            cnt <= cnt + CW'(1);
            if (samp) begin
              par_q <= rx;
              st    <= STOP;
            end
          end
        STOP:
          if (tick16_i) begin
            cnt <= cnt + CW'(1);
            if (samp) begin
              if (!rx) begin
                done_q <= 1'b1;
                if (zero_w && !stop2) begin
                  done_data <= 8'd0;
                  done_tag  <= 3'b100;
                  st        <= HOLD;
                end else begin
                  done_data <= char_w;
                  done_tag  <= {2'b01, parity_en_i && par_bad};
                  st        <= IDLE;
                end
              end else if (two_stop_i && !stop2) begin
                stop2 <= 1'b1;
              end else begin
                done_q    <= 1'b1;
                done_data <= char_w;
                done_tag  <= {2'b00, parity_en_i && par_bad};
                st        <= IDLE;
              end
            end
          end
        HOLD:
          if (tick16_i && rx) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  logic [7:0]  mem_d [DEPTH];
  logic [2:0]  mem_t [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt_f;
  logic        full, pop, push, fresh, arrive;
  logic [2:0]  head_t;
  logic        ovr_q, pe_q, fe_q, bi_q, err_any;
  logic [AW:0] lvl;

  assign full   = cnt_f == (AW+1)'(DEPTH);
  assign pop    = rd_i && (cnt_f != '0);
  assign push   = done_q && (!full || pop);
  assign head_t = mem_t[rp];
  assign arrive = fresh && (cnt_f != '0);

  always_ff @(posedge clk)
    if (push && !fifo_clr_i) begin
      mem_d[wp] <= done_data;
      mem_t[wp] <= done_tag;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_f <= '0;
      fresh <= 1'b0;
    end else if (fifo_clr_i) begin
      wp    <= '0;
      rp    <= '0;
      cnt_f <= '0;
      fresh <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt_f <= cnt_f + (AW+1)'(push) - (AW+1)'(pop);
      fresh <= (push && ((cnt_f == '0) || (pop && cnt_f == (AW+1)'(1))))
            || (pop && cnt_f >= (AW+1)'(2));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      ovr_q <= (done_q && full && !pop && !fifo_clr_i) || (ovr_q && !status_rd_i);
      pe_q  <= (arrive && head_t[0]) || (pe_q && !status_rd_i);
      fe_q  <= (arrive && head_t[1]) || (fe_q && !status_rd_i);
      bi_q  <= (arrive && head_t[2]) || (bi_q && !status_rd_i);
    end
  end

  always_comb begin
    err_any = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (({1'b0, AW'(i) - rp} < cnt_f) && (|mem_t[i])) err_any = 1'b1;
  end

  always_comb
    case (trig_sel_i)
      2'd0:    lvl = (AW+1)'(1);
      2'd1:    lvl = (AW+1)'(DEPTH/4);
      2'd2:    lvl = (AW+1)'(DEPTH/2);
      default: lvl = (AW+1)'(DEPTH-2);
    endcase

  assign rd_data_o     = mem_d[rp];
  assign count_o       = cnt_f;
  assign data_ready_o  = cnt_f != '0;
  assign overrun_o     = ovr_q;
  assign parity_err_o  = pe_q;
  assign framing_err_o = fe_q;
  assign break_o       = bi_q;
  assign fifo_err_o    = err_any;
  assign trig_o        = cnt_f >= lvl;
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_i,
  input logic                   fifo_clr_i,
  input logic                   status_rd_i,
  input logic [$clog2(DEPTH):0] count_o,
  input logic                   data_ready_o,
  input logic                   overrun_o,
  input logic                   fifo_err_o,
  input logic                   trig_o
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_o) <= DEPTH); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fifo_clr_i) |-> (int'(count_o) <= int'($past(count_o)) + 1) &&
                           (int'(count_o) + 1 >= int'($past(count_o)))); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && rd_i && !fifo_clr_i) |=> int'(count_o) <= 1); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr_i |=> (count_o == '0) && !fifo_err_o && !data_ready_o); // R12
  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> int'(count_o) == DEPTH); // R7
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun_o) |-> $past(status_rd_i)); // R8
  AST_ERR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err_o |-> data_ready_o); // R10
  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> data_ready_o); // R11
endmodule

bind serial_rx_core serial_rx_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .fifo_clr_i(fifo_clr_i),
  .status_rd_i(status_rd_i), .count_o(count_o), .data_ready_o(data_ready_o),
  .overrun_o(overrun_o), .fifo_err_o(fifo_err_o), .trig_o(trig_o)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  localparam int BITCLK = 32;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] wl = 2'd3, tsel = 2'd0;
  logic pen = 1'b0, pev = 1'b1, ts = 1'b0, rd = 1'b0, clr = 1'b0, srd = 1'b0;
  logic [7:0] rdata;
  logic [4:0] cnt;
  logic dr, ovr, pe, fe, bi, ferr, trg;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick), .rxd_i(rxd), .word_len_i(wl),
    .parity_en_i(pen), .parity_even_i(pev), .two_stop_i(ts), .trig_sel_i(tsel),
    .rd_i(rd), .fifo_clr_i(clr), .status_rd_i(srd), .rd_data_o(rdata),
    .count_o(cnt), .data_ready_o(dr), .overrun_o(ovr), .parity_err_o(pe),
    .framing_err_o(fe), .break_o(bi), .fifo_err_o(ferr), .trig_o(trg)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  task automatic line(input logic v, input int bits);
    rxd = v;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic badpar, input logic s1, input logic s2);
    int nb = int'(wl) + 5;
    line(1'b0, 1);
    for (int i = 0; i < nb; i++) line(d[i], 1);
    if (pen) line(par_of(d, pev) ^ badpar, 1);
    line(s1, 1);
    if (ts) line(s2, 1);
    line(1'b1, 1);
  endtask

  task automatic strobe_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe_srd();
    @(negedge clk) srd = 1'b1;
    @(negedge clk) srd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic epe, efe, bp, s1, s2;
    int kind;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R9 reset ready", int'(dr), 0);
    chk("R6 reset count", int'(cnt), 0);
    chk("R8 reset flags", int'({ovr, pe, fe, bi}), 0);
    chk("R11 reset trig", int'(trg), 0);

    // R1 short low pulse is rejected
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    line(1'b1, 2);
    chk("R1 glitch ignored", int'(cnt), 0);

    // R2 R3 R4 random characters
    for (int k = 0; k < 40; k++) begin
      wl = 2'($urandom % 4);
      pen = 1'($urandom % 2);
      pev = 1'($urandom % 2);
      ts = 1'($urandom % 2);
      d = 8'($urandom) & 8'((1 << (int'(wl) + 5)) - 1);
      kind = int'($urandom % 4);
      bp = 1'b0; s1 = 1'b1; s2 = 1'b1; epe = 1'b0; efe = 1'b0;
      if (kind == 1 && pen) begin bp = 1'b1; epe = 1'b1; end
      if (kind == 2) begin d = d | 8'd1; s1 = 1'b0; efe = 1'b1; end
      if (kind == 3 && ts) begin s2 = 1'b0; efe = 1'b1; end
      send(d, bp, s1, s2);
      chk("R6 one stored", int'(cnt), 1);
      chk("R2 data", int'(rdata), int'(d));
      chk("R3 parity tag", int'(pe), int'(epe));
      chk("R4 framing tag", int'(fe), int'(efe));
      chk("R10 tagged in queue", int'(ferr), int'(epe | efe));
      chk("R9 ready", int'(dr), 1);
      strobe_srd();
      chk("R8 cleared", int'({pe, fe, bi}), 0);
      strobe_rd();
      chk("R6 drained", int'(cnt), 0);
    end

    // R11 R7 R6 fill, thresholds, overrun
    wl = 2'd3; pen = 1'b0; ts = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send(8'(i + 1), 1'b0, 1'b1, 1'b1);
      for (int s = 0; s < 4; s++) begin
        tsel = 2'(s);
        @(negedge clk);
        chk("R11 trigger", int'(trg), int'((i + 1) >= lvl_of(s)));
      end
    end
    chk("R8 no overrun yet", int'(ovr), 0);
    send(8'hAA, 1'b0, 1'b1, 1'b1);
    chk("R7 overrun flag", int'(ovr), 1);
    chk("R7 count kept", int'(cnt), 16);
    chk("R7 head kept", int'(rdata), 1);
    for (int i = 0; i < 16; i++) begin
      chk("R6 order", int'(rdata), i + 1);
      strobe_rd();
    end
    strobe_rd();
    chk("R6 empty pop ignored", int'(cnt), 0);
    send(8'h3C, 1'b0, 1'b1, 1'b1);
    chk("R6 after empty pop", int'(rdata), 8'h3C);
    chk("R8 overrun sticky", int'(ovr), 1);
    strobe_srd();
    chk("R8 overrun cleared", int'(ovr), 0);
    strobe_rd();

    // R10 R8 tagged character behind a clean one
    pen = 1'b1; pev = 1'b1;
    send(8'h11, 1'b0, 1'b1, 1'b1);
    send(8'h22, 1'b1, 1'b1, 1'b1);
    chk("R10 error behind head", int'(ferr), 1);
    chk("R8 clean head", int'(pe), 0);
    strobe_rd();
    chk("R8 tagged head", int'(pe), 1);
    strobe_srd();
    chk("R8 cleared by status", int'(pe), 0);
    strobe_rd();
    chk("R10 none left", int'(ferr), 0);

    // R4 recovery after bad stop
    pen = 1'b0;
    send(8'h81, 1'b0, 1'b0, 1'b1);
    send(8'h42, 1'b0, 1'b1, 1'b1);
    chk("R4 two stored", int'(cnt), 2);
    chk("R4 framing flag", int'(fe), 1);
    strobe_rd();
    chk("R4 resync data", int'(rdata), 8'h42);
    strobe_rd();
    strobe_srd();

    // R5 break
    line(1'b0, 30);
    line(1'b1, 2);
    chk("R5 one char", int'(cnt), 1);
    chk("R5 zero data", int'(rdata), 0);
    chk("R5 break flag", int'(bi), 1);
    chk("R5 no framing", int'(fe), 0);
    send(8'h5A, 1'b0, 1'b1, 1'b1);
    chk("R5 resumes", int'(cnt), 2);

    // R12 clear
    chk("R10 break tagged", int'(ferr), 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R12 count", int'(cnt), 0);
    chk("R12 ready", int'(dr), 0);
    chk("R12 error flag", int'(ferr), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule